// File: doc/BRIEF.md
# Debounced External Interrupt Controller

This block watches eight input-only pins and turns each into a clean, debounced level that software can read and that can raise an interrupt. Every pin passes through a two-flop synchronizer and then a per-channel stability filter. The filter counts a shared millisecond tick. The filtered level changes only after the synchronized pin has held its new value for the programmed number of milliseconds, from 1 up to 4095.

Interrupts use a single-shot scheme. Software arms a channel. The channel then latches its raw status bit on the first qualifying filtered event and disarms itself. No further event is latched on that channel until it is armed again. A qualifying event is a rising edge, a falling edge, a high level or a low level, chosen per channel. The raw status is ANDed with an enable register, and the combined interrupt output is the OR of those masked bits.

All configuration goes through a flat 32-bit register bus. The bus has a write strobe, a byte address and write data. Read data is combinational on the address.

Top module: `dbirq_top`

## Requirements
- R1: After reset, every readable register returns 0 and `irq_o` is low.
- R2: The registers sit at these byte offsets: filtered data 0x00, channel enable 0x04, event type 0x14, interrupt enable 0x18, raw status 0x1C, masked status 0x20, clear 0x24, arm 0x28, and channel n control at 0x40+4n. Only control bits [11:0] are stored, and the other control bits read 0. Enable, interrupt enable and status use bit n for channel n. Clear, arm and unmapped offsets read 0, and writes to unmapped offsets have no effect.
- R3: A tick occurs every CLKS_PER_MS clocks. A channel's filtered level takes the synchronized pin value only after the pin has differed from the filtered level at N consecutive ticks, where N is control bits [11:0]. A disturbance that spans fewer than N ticks leaves the filtered level unchanged.
- R4: A debounce value of 0 behaves as 1: the level follows after a single tick.
- R5: The data register returns the filtered level only for channels whose enable bit is set. Disabled channels read 0, but their filter keeps running.
- R6: Each channel has a 3-bit event field at event-register bits [4n+2:4n]. Bit 0 selects falling edge or low level. Bit 1 selects rising edge or high level. Bit 2 selects level mode (1) instead of edge mode (0). Bit 4n+3 reads 0.
- R7: Writing 1 to an arm bit arms that channel, and writing 0 has no effect. An armed channel sets its raw status bit on the next qualifying event and disarms in the same cycle, so later events are not latched until the channel is re-armed.
- R8: Writing 1 to a clear bit clears that raw status bit. Writing 0 leaves it unchanged.
- R9: Masked status equals raw status AND interrupt enable. `irq_o` is high exactly when some masked status bit is set.
- R10: A channel whose enable bit is clear never sets its raw status bit, even if it is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_CH | Asynchronous external pins |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A stuck or miscounted stability counter shows up in the data register. The level changes either a tick too early, which lets a short glitch through, or never. Either fault is visible within one debounce window plus one tick. A lost disarm or a wrongly held arm bit shows up on the second edge after an event, as a raw status bit that reappears after a clear. A wrong enable gate shows on `irq_o` in the same cycle that the enable or status register changes.

// File: rtl/dbirq_pkg.sv
package dbirq_pkg;
  localparam int unsigned OFF_DATA = 'h00;
  localparam int unsigned OFF_MASK = 'h04;
  localparam int unsigned OFF_EVT  = 'h14;
  localparam int unsigned OFF_IE   = 'h18;
  localparam int unsigned OFF_RAW  = 'h1C;
  localparam int unsigned OFF_MIS  = 'h20;
  localparam int unsigned OFF_CLR  = 'h24;
  localparam int unsigned OFF_TRIG = 'h28;
  localparam int unsigned OFF_CTRL = 'h40;

  // event field bit positions within a channel nibble
  localparam int EV_LO  = 0;
  localparam int EV_HI  = 1;
  localparam int EV_LVL = 2;
  localparam int EV_W   = 3;
  localparam int EV_STRIDE = 4;
endpackage

// File: rtl/dbirq_tick.sv
module dbirq_tick #(
  parameter int CLKS_PER_MS = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/dbirq_filter.sv
module dbirq_filter #(
  parameter int DBNC_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              tick_i,
  input  logic [DBNC_W-1:0] limit_i,
  output logic              lvl_o
);
  logic              s1_q, s2_q, lvl_q;
  logic [DBNC_W-1:0] cnt_q;
  logic [DBNC_W:0]   lim, cnt_nx;

  // zero limit behaves as one tick
  assign lim    = (limit_i == '0) ? (DBNC_W+1)'(1) : {1'b0, limit_i};
  assign cnt_nx = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      if (s2_q == lvl_q) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_nx >= lim) begin
          lvl_q <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_nx[DBNC_W-1:0];
        end
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/dbirq_regs.sv
module dbirq_regs
  import dbirq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DBNC_W = 12,
  parameter int ADDR_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [31:0]                    wdata_i,
  input  logic [NUM_CH-1:0]              lvl_i,
  output logic [31:0]                    rdata_o,
  output logic                           irq_o,
  output logic [NUM_CH-1:0]              mask_o,
  output logic [NUM_CH-1:0]              raw_o,
  output logic [NUM_CH-1:0]              arm_o,
  output logic [NUM_CH-1:0][DBNC_W-1:0]  limit_o
);
  logic [NUM_CH-1:0]             mask_q, ie_q, raw_q, arm_q, lvl_d_q;
  logic [NUM_CH-1:0]             hit, fire, clr_bits, arm_bits;
  logic [NUM_CH-1:0][EV_W-1:0]   evt_q;
  logic [NUM_CH-1:0][DBNC_W-1:0] ctrl_q;
  logic [NUM_CH-1:0]             wr_ctrl;
  logic                          wr_mask, wr_evt, wr_ie, wr_clr, wr_trig;

  assign wr_mask = we_i && (addr_i == ADDR_W'(OFF_MASK));
  assign wr_evt  = we_i && (addr_i == ADDR_W'(OFF_EVT));
  assign wr_ie   = we_i && (addr_i == ADDR_W'(OFF_IE));
  assign wr_clr  = we_i && (addr_i == ADDR_W'(OFF_CLR));
  assign wr_trig = we_i && (addr_i == ADDR_W'(OFF_TRIG));

  assign clr_bits = wr_clr  ? wdata_i[NUM_CH-1:0] : '0;
  assign arm_bits = wr_trig ? wdata_i[NUM_CH-1:0] : '0;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic rise, fall, hi_lvl, lo_lvl;
    assign wr_ctrl[g] = we_i && (addr_i == ADDR_W'(OFF_CTRL + 4*g));
    assign rise   = lvl_i[g] & ~lvl_d_q[g];
    assign fall   = ~lvl_i[g] & lvl_d_q[g];
    assign hi_lvl = lvl_i[g];
    assign lo_lvl = ~lvl_i[g];
    always_comb begin
      if (evt_q[g][EV_LVL]) begin
        hit[g] = (evt_q[g][EV_HI] & hi_lvl) | (evt_q[g][EV_LO] & lo_lvl);
      end else begin
        hit[g] = (evt_q[g][EV_HI] & rise) | (evt_q[g][EV_LO] & fall);
      end
    end
  end

  assign fire = arm_q & mask_q & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      ie_q    <= '0;
      raw_q   <= '0;
      arm_q   <= '0;
      lvl_d_q <= '0;
      evt_q   <= '0;
      ctrl_q  <= '0;
    end else begin
      lvl_d_q <= lvl_i;
      if (wr_mask) mask_q <= wdata_i[NUM_CH-1:0];
      if (wr_ie)   ie_q   <= wdata_i[NUM_CH-1:0];
      for (int i = 0; i < NUM_CH; i++) begin
        if (wr_evt)     evt_q[i]  <= wdata_i[EV_STRIDE*i +: EV_W];
        if (wr_ctrl[i]) ctrl_q[i] <= wdata_i[DBNC_W-1:0];
      end
      // a new event wins over a same-cycle clear; a re-arm wins over disarm
      raw_q <= (raw_q & ~clr_bits) | fire;
      arm_q <= (arm_q & ~fire) | arm_bits;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_DATA)) rdata_o[NUM_CH-1:0] = lvl_i & mask_q;
    if (addr_i == ADDR_W'(OFF_MASK)) rdata_o[NUM_CH-1:0] = mask_q;
    if (addr_i == ADDR_W'(OFF_IE))   rdata_o[NUM_CH-1:0] = ie_q;
    if (addr_i == ADDR_W'(OFF_RAW))  rdata_o[NUM_CH-1:0] = raw_q;
    if (addr_i == ADDR_W'(OFF_MIS))  rdata_o[NUM_CH-1:0] = raw_q & ie_q;
    if (addr_i == ADDR_W'(OFF_EVT)) begin
      for (int i = 0; i < NUM_CH; i++) rdata_o[EV_STRIDE*i +: EV_W] = evt_q[i];
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_i == ADDR_W'(OFF_CTRL + 4*i)) rdata_o[DBNC_W-1:0] = ctrl_q[i];
    end
  end

  assign irq_o   = |(raw_q & ie_q);
  assign mask_o  = mask_q;
  assign raw_o   = raw_q;
  assign arm_o   = arm_q;
  assign limit_o = ctrl_q;
endmodule

// File: rtl/dbirq_top.sv
module dbirq_top #(
  parameter int NUM_CH      = 8,
  parameter int CLKS_PER_MS = 125000,
  parameter int DBNC_W      = 12,
  parameter int ADDR_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  logic                          tick;
  logic [NUM_CH-1:0]             filt_lvl, mask_q, raw_q, arm_q;
  logic [NUM_CH-1:0][DBNC_W-1:0] limit;

  dbirq_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flt
    dbirq_filter #(.DBNC_W(DBNC_W)) u_flt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_i[g]),
      .tick_i (tick),
      .limit_i(limit[g]),
      .lvl_o  (filt_lvl[g])
    );
  end

  dbirq_regs #(.NUM_CH(NUM_CH), .DBNC_W(DBNC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .lvl_i  (filt_lvl),
    .rdata_o(rdata_o),
    .irq_o  (irq_o),
    .mask_o (mask_q),
    .raw_o  (raw_q),
    .arm_o  (arm_q),
    .limit_o(limit)
  );
endmodule

// File: rtl/dbirq_chk.sv
module dbirq_chk
  import dbirq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              irq_o,
  input logic              tick_i,
  input logic [NUM_CH-1:0] filt_i,
  input logic [NUM_CH-1:0] mask_i,
  input logic [NUM_CH-1:0] raw_i,
  input logic [NUM_CH-1:0] arm_i
);
  AST_IRQ_VS_MIS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFF_MIS)) |-> (irq_o == (rdata_o != 32'h0))); // R9

  AST_FILT_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_i != $past(filt_i)) |-> $past(tick_i)); // R3

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    AST_RAW_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(raw_i[g]) |-> $past(arm_i[g])); // R7

    AST_DISARM_AFTER_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(raw_i[g]) && !$past(we_i && addr_i == ADDR_W'(OFF_TRIG) && wdata_i[g]))
        |-> !arm_i[g]); // R7

    AST_RAW_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(raw_i[g]) |-> $past(mask_i[g])); // R10

    AST_RAW_FALL_BY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(raw_i[g]) |-> $past(we_i && addr_i == ADDR_W'(OFF_CLR) && wdata_i[g])); // R8
  end
endmodule

bind dbirq_top dbirq_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .tick_i (tick),
  .filt_i (filt_lvl),
  .mask_i (mask_q),
  .raw_i  (raw_q),
  .arm_i  (arm_q)
);

// File: tb/tb_dbirq_top.sv
module tb_dbirq_top;
  localparam int NUM_CH = 8;
  localparam int CPM    = 4;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NUM_CH-1:0] pin = '0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              irq;
  int                n_tests = 0;
  int                n_fail = 0;
  bit                done = 1'b0;

  always #4 clk = ~clk;

  dbirq_top #(.NUM_CH(NUM_CH), .CLKS_PER_MS(CPM), .DBNC_W(12), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  // first 7 entries: reset values (R1); rest: map and field widths (R2, R6)
  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 32'h0, 32'h0},
    '{1'b0, 8'h04, 32'h0, 32'h0},
    '{1'b0, 8'h14, 32'h0, 32'h0},
    '{1'b0, 8'h18, 32'h0, 32'h0},
    '{1'b0, 8'h1C, 32'h0, 32'h0},
    '{1'b0, 8'h20, 32'h0, 32'h0},
    '{1'b0, 8'h40, 32'h0, 32'h0},
    '{1'b1, 8'h04, 32'hFFFF_FFAB, 32'h0000_00AB},
    '{1'b1, 8'h18, 32'h0000_013C, 32'h0000_003C},
    '{1'b1, 8'h14, 32'hFFFF_FFFF, 32'h7777_7777},
    '{1'b1, 8'h40, 32'hFFFF_F005, 32'h0000_0005},
    '{1'b1, 8'h5C, 32'h0000_1FFF, 32'h0000_0FFF},
    '{1'b1, 8'h24, 32'h0000_00FF, 32'h0},
    '{1'b1, 8'h28, 32'h0000_0000, 32'h0},
    '{1'b0, 8'h30, 32'h0, 32'h0},
    '{1'b1, 8'h30, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 8'h20, 32'h0, 32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(2);
    check("R1 irq at reset", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].a, VEC[i].wd);
      rd(VEC[i].a, v);
      check((i < 7) ? "R1 reset value" : "R2 map readback", v, VEC[i].exp);
    end

    // clean restart
    @(negedge clk); rst_ni = 1'b0;
    wait_cyc(2); rst_ni = 1'b1;
    wait_cyc(2);

    // R3: debounce of 3 ticks on channel 0
    wr(8'h40, 32'd3);
    wr(8'h04, 32'h01);
    pin[0] = 1'b1;
    wait_cyc(6);
    rd(8'h00, v); check("R3 no early change", {31'b0, v[0]}, 32'h0);
    wait_cyc(30);
    rd(8'h00, v); check("R3 settled high", {31'b0, v[0]}, 32'h1);
    pin[0] = 1'b0; wait_cyc(5); pin[0] = 1'b1;
    wait_cyc(30);
    rd(8'h00, v); check("R3 glitch rejected", {31'b0, v[0]}, 32'h1);
    pin[0] = 1'b0;
    wait_cyc(30);
    rd(8'h00, v); check("R3 settled low", {31'b0, v[0]}, 32'h0);

    // R4: zero debounce on channel 1
    wr(8'h04, 32'h03);
    pin[1] = 1'b1;
    wait_cyc(10);
    rd(8'h00, v); check("R4 zero acts as one", {31'b0, v[1]}, 32'h1);

    // R5: channel 2 disabled, filter still runs
    wr(8'h48, 32'd1);
    pin[2] = 1'b1;
    wait_cyc(20);
    rd(8'h00, v); check("R5 disabled reads 0", {31'b0, v[2]}, 32'h0);
    wr(8'h04, 32'h07);
    rd(8'h00, v); check("R5 enabled reads level", {31'b0, v[2]}, 32'h1);

    // R6/R7/R9: rising edge on channel 0, single trigger
    wr(8'h14, 32'h2);
    wr(8'h18, 32'h01);
    wr(8'h28, 32'h01);
    pin[0] = 1'b1; wait_cyc(30);
    rd(8'h1C, v); check("R7 armed rise latched", {31'b0, v[0]}, 32'h1);
    rd(8'h20, v); check("R9 masked status", {31'b0, v[0]}, 32'h1);
    check("R9 irq high", {31'b0, irq}, 32'h1);
    wr(8'h24, 32'h00);
    rd(8'h1C, v); check("R8 clear 0 no effect", {31'b0, v[0]}, 32'h1);
    wr(8'h24, 32'h01);
    rd(8'h1C, v); check("R8 clear 1", {31'b0, v[0]}, 32'h0);
    check("R9 irq low after clear", {31'b0, irq}, 32'h0);
    pin[0] = 1'b0; wait_cyc(30);
    wr(8'h28, 32'h00);
    pin[0] = 1'b1; wait_cyc(30);
    rd(8'h1C, v); check("R7 disarmed, arm 0 ignored", {31'b0, v[0]}, 32'h0);
    wr(8'h28, 32'h01);
    pin[0] = 1'b0; wait_cyc(30);
    rd(8'h1C, v); check("R6 falling ignored in rise mode", {31'b0, v[0]}, 32'h0);
    pin[0] = 1'b1; wait_cyc(30);
    rd(8'h1C, v); check("R7 re-armed rise", {31'b0, v[0]}, 32'h1);
    wr(8'h24, 32'h01);

    // R6/R9: falling edge on channel 1 with its interrupt disabled
    wr(8'h14, 32'h10);
    wr(8'h28, 32'h02);
    pin[1] = 1'b0; wait_cyc(15);
    rd(8'h1C, v); check("R6 falling latched", {31'b0, v[1]}, 32'h1);
    rd(8'h20, v); check("R9 masked by enable", v, 32'h0);
    check("R9 irq stays low", {31'b0, irq}, 32'h0);
    wr(8'h24, 32'h02);

    // R6: high level on channel 2 fires without an edge
    wr(8'h14, 32'h600);
    wr(8'h28, 32'h04);
    wait_cyc(3);
    rd(8'h1C, v); check("R6 level high", {31'b0, v[2]}, 32'h1);
    check("R9 irq low, enable off", {31'b0, irq}, 32'h0);
    wr(8'h18, 32'h04);
    check("R9 irq follows enable", {31'b0, irq}, 32'h1);

    // R10: disabled channel 3 armed, never latches
    wr(8'h4C, 32'd1);
    wr(8'h14, 32'h2000);
    wr(8'h28, 32'h08);
    pin[3] = 1'b1; wait_cyc(20);
    rd(8'h1C, v); check("R10 disabled no status", {31'b0, v[3]}, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule